// File: doc/BRIEF.md
# Debug-Port Flash Programming Sequencer

This block runs complete flash operations on a microcontroller target reached through a two-wire debug master. A single start pulse with an operation code launches one of five jobs: unlocking flash programming, reading a block, writing a block, erasing the whole device, or pulsing a target reset. The sequencer drives the master one primitive at a time. The primitives are an address-register select, an address-register read, a data-register write, a data-register read, and a reset pulse. The sequencer waits for each primitive to complete before it issues the next.

Every flash command follows a fixed handshake script. The sequencer polls the target's address register for its input-busy and output-ready flags. It checks each status byte the target returns. For block reads and writes it moves data between the target and a local 128-byte buffer through a plain address/data port. Poll spacing and the unlock settling delay are both counted from a free-running 1 µs tick. When an operation ends, the block pulses a done flag and holds a result code and the number of bytes moved.

Top module: `flash_prog_seq`

## Requirements
- R1: After reset, done, m_req and buf_we are low and err_code and xfer_count are 0. Done is a single-cycle pulse, and err_code and xfer_count hold their values from that pulse until the next start.
- R2: Operation code 0 (unlock) selects address 0x02, writes 0x02 and then 0x01 to the data register, and then waits ENABLE_WAIT_US ticks before done. On completion, flash commands are permitted.
- R3: Operation codes 1 (read), 2 (write) and 3 (erase) finish with err_code 1 (refused) and issue no master request unless an unlock has completed since the last reset operation.
- R4: Operation code 4 issues exactly one master reset request (master op 4), finishes with err_code 0, and revokes the unlock.
- R5: A block command selects address 0xB4. Its data-register writes are, in order: the command (0x06 read, 0x07 write), the offset high byte, the offset low byte, and the length. An input-busy poll follows each of these writes, and an output-ready poll and a status read sit after the command and after the length.
- R6: A status byte other than 0x0D ends the operation at once with err_code 2, and no further data-register writes are issued.
- R7: An input-busy poll reads the address register (master op 1) until bit 1 is 0. It allows IN_TRIES reads spaced one tick apart and succeeds if the last allowed read is clear. Otherwise it ends with err_code 3.
- R8: An output-ready poll reads the address register until bit 0 is 1, within OUT_TRIES reads. Otherwise it ends with err_code 3.
- R9: The transfer length is the minimum of 128, count, and flash_size minus offset. On success, xfer_count equals that length.
- R10: A read at or past flash_size, or any read or write with a length of 0, finishes with err_code 0, xfer_count 0 and no master request. A write at or past flash_size, or an operation code of 5 to 7, finishes with err_code 4 and no master request.
- R11: A read stores the k-th data byte that follows the two status reads at buffer address k. A write sends buffer byte k as the k-th data-register write after the length. In a read, an output-ready poll comes before each byte. In a write, an input-busy poll follows each byte, and one output-ready poll closes the transfer.
- R12: Erase writes the command 0x03, and after an accepted status writes the arming bytes 0xDE, 0xAD and 0xA5. An input-busy poll follows each arming byte, and a final output-ready poll ends the operation.
- R13: A master completion with m_fail high ends the operation with err_code 3. Master op codes are 0 address select, 1 address read, 2 data write, 3 data read, 4 reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| tick_us | input | 1 | One-cycle pulse every microsecond |
| op_start | input | 1 | Start pulse, taken while idle |
| op_code | input | 3 | 0 unlock, 1 read, 2 write, 3 erase, 4 reset |
| offset | input | 16 | Flash byte offset |
| count | input | 16 | Requested byte count |
| flash_size | input | 17 | Total flash bytes |
| done | output | 1 | Operation finished (one cycle) |
| err_code | output | 3 | 0 ok, 1 refused, 2 status, 3 timeout, 4 rejected |
| xfer_count | output | 8 | Bytes moved by the last operation |
| m_req | output | 1 | Master request pulse |
| m_op | output | 3 | Master primitive code |
| m_wdata | output | 8 | Byte for select or data write |
| m_done | input | 1 | Master primitive finished |
| m_fail | input | 1 | Master primitive failed |
| m_rdata | input | 8 | Byte returned by a master read |
| buf_addr | output | 7 | Local buffer address |
| buf_we | output | 1 | Local buffer write strobe |
| buf_wdata | output | 8 | Byte written to the buffer |
| buf_rdata | input | 8 | Byte read from the buffer |

## Verification
A poll can reach its try limit in the same response that satisfies it. The poll must then succeed and must not report a timeout. To provoke this, the bench's target keeps the busy flag set for 19 address reads after each data write and then clears it. The bench expects err_code 0. Keeping the flag set for 20 reads must give err_code 3 after exactly 20 address reads. The last byte of a block transfer likewise completes in the same step that leaves the byte loop. The bench judges this by xfer_count and by the data-register write log at the 128-byte and 1-byte lengths.

// File: rtl/fps_pkg.sv
// Shared codes for the flash programming sequencer.
package fps_pkg;
    localparam int OFF_W = 16;

    typedef enum logic [2:0] {
        OP_UNLOCK = 3'd0, OP_READ = 3'd1, OP_WRITE = 3'd2,
        OP_ERASE  = 3'd3, OP_RESET = 3'd4
    } op_e;

    typedef enum logic [2:0] {
        M_SEL = 3'd0, M_ARRD = 3'd1, M_DRWR = 3'd2, M_DRRD = 3'd3, M_RST = 3'd4
    } mop_e;

    typedef enum logic [2:0] {
        E_OK = 3'd0, E_BUSY = 3'd1, E_STATUS = 3'd2, E_TIMEOUT = 3'd3, E_REJECT = 3'd4
    } err_e;

    typedef enum logic [3:0] {
        K_END, K_SEL, K_WR, K_PIB, K_POR, K_RDS, K_RDB, K_DLY, K_RST
    } kind_e;

    typedef struct packed {
        kind_e      kind;
        logic [7:0] val;
    } step_t;

    localparam logic [7:0] REG_CTL   = 8'h02;
    localparam logic [7:0] REG_DAT   = 8'hB4;
    localparam logic [7:0] KEY_A     = 8'h02;
    localparam logic [7:0] KEY_B     = 8'h01;
    localparam logic [7:0] CMD_ERASE = 8'h03;
    localparam logic [7:0] CMD_READ  = 8'h06;
    localparam logic [7:0] CMD_WRITE = 8'h07;
    localparam logic [7:0] ST_OK     = 8'h0D;
    localparam logic [7:0] ARM_0     = 8'hDE;
    localparam logic [7:0] ARM_1     = 8'hAD;
    localparam logic [7:0] ARM_2     = 8'hA5;

    // Byte-loop step indices of the block scripts.
    localparam logic [4:0] LOOP_FIRST = 5'd13;
    localparam logic [4:0] LOOP_LAST  = 5'd14;
endpackage

// File: rtl/fps_clip.sv
// Transfer length computation.
// Assumes MAX_XFER fits in LW bits and in the one-byte length field.
module fps_clip import fps_pkg::*; #(
    parameter int MAX_XFER = 128,
    parameter int LW       = 8
) (
    input  logic [OFF_W-1:0] off,
    input  logic [OFF_W-1:0] cnt,
    input  logic [OFF_W:0]   size,
    output logic [LW-1:0]    len,
    output logic             past_end
);
    logic [OFF_W:0] remain;
    logic [OFF_W:0] capped;

    // Clip the request to the per-transfer cap and to the end of flash.
    always_comb begin
        past_end = ({1'b0, off} >= size);
        remain   = size - {1'b0, off};
        capped   = ({1'b0, cnt} < (OFF_W+1)'(MAX_XFER)) ? {1'b0, cnt} : (OFF_W+1)'(MAX_XFER);
        if (past_end)
            len = '0;
        else if (remain < capped)
            len = LW'(remain);
        else
            len = LW'(capped);
    end
endmodule

// File: rtl/fps_script.sv
// Handshake script: maps (operation, step index) to one micro-step.
// Block read, block write and erase share the prelude layout.
module fps_script import fps_pkg::*; #(
    parameter int LW = 8
) (
    input  op_e              op,
    input  logic [4:0]       pc,
    input  logic [OFF_W-1:0] off,
    input  logic [LW-1:0]    len,
    input  logic [7:0]       buf_byte,
    output step_t            step
);
    function automatic step_t mk(kind_e k, logic [7:0] v);
        step_t s;
        s.kind = k;
        s.val  = v;
        return s;
    endfunction

    logic is_rd, is_er;
    logic [7:0] cmd;

    // Pick the micro-step for the current index.
    always_comb begin
        is_rd = (op == OP_READ);
        is_er = (op == OP_ERASE);
        cmd   = is_er ? CMD_ERASE : (is_rd ? CMD_READ : CMD_WRITE);
        step  = mk(K_END, 8'h00);
        case (op)
            OP_UNLOCK: case (pc)
                5'd0: step = mk(K_SEL, REG_CTL);
                5'd1: step = mk(K_WR, KEY_A);
                5'd2: step = mk(K_WR, KEY_B);
                5'd3: step = mk(K_DLY, 8'h00);
                default: step = mk(K_END, 8'h00);
            endcase
            OP_RESET: if (pc == 5'd0) step = mk(K_RST, 8'h00);
            OP_READ, OP_WRITE, OP_ERASE: case (pc)
                5'd0:  step = mk(K_SEL, REG_DAT);
                5'd1:  step = mk(K_WR, cmd);
                5'd2, 5'd6, 5'd8, 5'd10: step = mk(K_PIB, 8'h00);
                5'd3, 5'd11: step = mk(K_POR, 8'h00);
                5'd4:  step = mk(K_RDS, 8'h00);
                5'd5:  step = mk(K_WR, is_er ? ARM_0 : off[15:8]);
                5'd7:  step = mk(K_WR, is_er ? ARM_1 : off[7:0]);
                5'd9:  step = mk(K_WR, is_er ? ARM_2 : 8'(len));
                5'd12: step = is_er ? mk(K_END, 8'h00) : mk(K_RDS, 8'h00);
                5'd13: step = is_er ? mk(K_END, 8'h00) :
                              (is_rd ? mk(K_POR, 8'h00) : mk(K_WR, buf_byte));
                5'd14: step = is_er ? mk(K_END, 8'h00) :
                              (is_rd ? mk(K_RDB, 8'h00) : mk(K_PIB, 8'h00));
                5'd15: step = (op == OP_WRITE) ? mk(K_POR, 8'h00) : mk(K_END, 8'h00);
                default: step = mk(K_END, 8'h00);
            endcase
            default: step = mk(K_END, 8'h00);
        endcase
    end
endmodule

// File: rtl/fps_delay.sv
// Tick counter for the unlock settling wait. Counts tick pulses while
// run is high and clears when run drops.
module fps_delay #(
    parameter int LIMIT = 25000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    input  logic tick,
    output logic expired
);
    localparam int CW = $clog2(LIMIT + 1);
    logic [CW-1:0] cnt;

    // Count ticks up to the limit, cleared outside the wait.
    always_ff @(posedge clk) begin
        if (!rst_n || !run)
            cnt <= '0;
        else if (tick && !expired)
            cnt <= cnt + 1'b1;
    end

    assign expired = (cnt == CW'(LIMIT));
endmodule

// File: rtl/flash_prog_seq.sv
// Flash programming sequencer. It runs unlock, block read, block write,
// erase and target reset as scripts of master primitives. Assumes the
// master accepts one m_req at a time and answers each with one m_done
// pulse. Assumes OUT_TRIES >= IN_TRIES and MAX_XFER <= 128.
module flash_prog_seq import fps_pkg::*; #(
    parameter int ENABLE_WAIT_US = 25000,
    parameter int IN_TRIES       = 20,
    parameter int OUT_TRIES      = 10000,
    parameter int MAX_XFER       = 128
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        tick_us,
    input  logic                        op_start,
    input  logic [2:0]                  op_code,
    input  logic [15:0]                 offset,
    input  logic [15:0]                 count,
    input  logic [16:0]                 flash_size,
    output logic                        done,
    output logic [2:0]                  err_code,
    output logic [7:0]                  xfer_count,
    output logic                        m_req,
    output logic [2:0]                  m_op,
    output logic [7:0]                  m_wdata,
    input  logic                        m_done,
    input  logic                        m_fail,
    input  logic [7:0]                  m_rdata,
    output logic [$clog2(MAX_XFER)-1:0] buf_addr,
    output logic                        buf_we,
    output logic [7:0]                  buf_wdata,
    input  logic [7:0]                  buf_rdata
);
    localparam int LW = 8;
    localparam int AW = $clog2(MAX_XFER);
    localparam int TW = $clog2(OUT_TRIES + 1);

    typedef enum logic [2:0] {S_IDLE, S_STEP, S_WAIT, S_GAP, S_DLY} st_e;

    st_e              st;
    op_e              op_q;
    logic [4:0]       pc;
    logic [LW-1:0]    idx, len_q, xfer_q;
    logic [TW-1:0]    tries;
    logic             unlocked;
    logic [OFF_W-1:0] off_q;
    err_e             err_q;
    logic [AW-1:0]    wa_q;
    step_t            stp;
    logic [LW-1:0]    clip_len;
    logic             past_end, dly_done;
    logic             r_ok, r_retry, r_fail;
    err_e             r_code;
    logic             known_op, flash_op;

    fps_clip #(.MAX_XFER(MAX_XFER), .LW(LW)) u_clip (
        .off(offset), .cnt(count), .size(flash_size),
        .len(clip_len), .past_end(past_end));

    fps_script #(.LW(LW)) u_scr (
        .op(op_q), .pc(pc), .off(off_q), .len(len_q),
        .buf_byte(buf_rdata), .step(stp));

    fps_delay #(.LIMIT(ENABLE_WAIT_US)) u_dly (
        .clk(clk), .rst_n(rst_n), .run(st == S_DLY),
        .tick(tick_us), .expired(dly_done));

    // Classify the incoming operation code.
    always_comb begin
        known_op = (op_code <= 3'd4);
        flash_op = (op_code == 3'd1) || (op_code == 3'd2) || (op_code == 3'd3);
    end

    // Judge a master response against the current micro-step.
    always_comb begin
        r_ok = 1'b0; r_retry = 1'b0; r_fail = 1'b0; r_code = E_OK;
        if (m_fail) begin
            r_fail = 1'b1; r_code = E_TIMEOUT;
        end else begin
            case (stp.kind)
                K_PIB: if (!m_rdata[1]) r_ok = 1'b1;
                       else if (tries == TW'(IN_TRIES - 1)) begin r_fail = 1'b1; r_code = E_TIMEOUT; end
                       else r_retry = 1'b1;
                K_POR: if (m_rdata[0]) r_ok = 1'b1;
                       else if (tries == TW'(OUT_TRIES - 1)) begin r_fail = 1'b1; r_code = E_TIMEOUT; end
                       else r_retry = 1'b1;
                K_RDS: if (m_rdata == ST_OK) r_ok = 1'b1;
                       else begin r_fail = 1'b1; r_code = E_STATUS; end
                default: r_ok = 1'b1;
            endcase
        end
    end

    // Main sequencer: start checks, issue, response handling, loop, delay.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st <= S_IDLE; op_q <= OP_UNLOCK; pc <= '0; idx <= '0; len_q <= '0;
            xfer_q <= '0; tries <= '0; unlocked <= 1'b0; off_q <= '0; err_q <= E_OK;
            wa_q <= '0; done <= 1'b0; m_req <= 1'b0; m_op <= '0; m_wdata <= '0;
            buf_we <= 1'b0; buf_wdata <= '0;
        end else begin
            done   <= 1'b0;
            m_req  <= 1'b0;
            buf_we <= 1'b0;
            case (st)
                S_IDLE: if (op_start) begin
                    op_q <= op_e'(op_code); off_q <= offset; len_q <= clip_len;
                    pc <= '0; idx <= '0; tries <= '0; xfer_q <= '0;
                    if (!known_op) begin
                        done <= 1'b1; err_q <= E_REJECT;
                    end else if (flash_op && !unlocked) begin
                        done <= 1'b1; err_q <= E_BUSY;
                    end else if (op_code == 3'd2 && past_end) begin
                        done <= 1'b1; err_q <= E_REJECT;
                    end else if (op_code != 3'd3 && flash_op && clip_len == '0) begin
                        done <= 1'b1; err_q <= E_OK;
                    end else begin
                        if (op_code == 3'd4) unlocked <= 1'b0;
                        st <= S_STEP;
                    end
                end
                S_STEP: case (stp.kind)
                    K_END: begin
                        done <= 1'b1; err_q <= E_OK; st <= S_IDLE;
                        if (op_q == OP_UNLOCK) unlocked <= 1'b1;
                    end
                    K_DLY: st <= S_DLY;
                    default: begin
                        m_req   <= 1'b1;
                        m_wdata <= stp.val;
                        case (stp.kind)
                            K_SEL:        m_op <= M_SEL;
                            K_WR:         m_op <= M_DRWR;
                            K_PIB, K_POR: m_op <= M_ARRD;
                            K_RST:        m_op <= M_RST;
                            default:      m_op <= M_DRRD;
                        endcase
                        st <= S_WAIT;
                    end
                endcase
                S_WAIT: if (m_done) begin
                    if (r_fail) begin
                        done <= 1'b1; err_q <= r_code; st <= S_IDLE;
                    end else if (r_retry) begin
                        tries <= tries + 1'b1; st <= S_GAP;
                    end else if (r_ok) begin
                        tries <= '0; st <= S_STEP;
                        if (stp.kind == K_RDB) begin
                            buf_we <= 1'b1; buf_wdata <= m_rdata; wa_q <= idx[AW-1:0];
                        end
                        if (pc == LOOP_LAST) begin
                            xfer_q <= xfer_q + 1'b1;
                            if ({1'b0, idx} + 9'd1 < {1'b0, len_q}) begin
                                idx <= idx + 1'b1; pc <= LOOP_FIRST;
                            end else begin
                                pc <= pc + 1'b1;
                            end
                        end else begin
                            pc <= pc + 1'b1;
                        end
                    end
                end
                S_GAP: if (tick_us) st <= S_STEP;
                S_DLY: if (dly_done) begin pc <= pc + 1'b1; st <= S_STEP; end
                default: st <= S_IDLE;
            endcase
        end
    end

    assign err_code   = err_q;
    assign xfer_count = xfer_q;
    assign buf_addr   = buf_we ? wa_q : idx[AW-1:0];
endmodule

// File: rtl/flash_prog_seq_chk.sv
// Protocol checker for flash_prog_seq. It tracks operation and master
// request state from the ports only, and is attached by bind.
module flash_prog_seq_chk #(
    parameter int MAX_XFER  = 128,
    parameter int IN_TRIES  = 20,
    parameter int OUT_TRIES = 10000
) (
    input logic       clk,
    input logic       rst_n,
    input logic       op_start,
    input logic       done,
    input logic [2:0] err_code,
    input logic [7:0] xfer_count,
    input logic       m_req,
    input logic [2:0] m_op,
    input logic       m_done,
    input logic       buf_we
);
    localparam int RW = $clog2(IN_TRIES + OUT_TRIES + 2);
    logic busy, outst, req_seen;
    logic [RW-1:0] ar_run;

    // Port-level view of operation, outstanding request and poll run length.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy <= 1'b0; outst <= 1'b0; req_seen <= 1'b0; ar_run <= '0;
        end else begin
            if (op_start && (!busy || done)) begin
                busy <= 1'b1; req_seen <= 1'b0;
            end else if (done) begin
                busy <= 1'b0;
            end
            if (m_req) req_seen <= 1'b1;
            if (m_req) outst <= 1'b1;
            else if (m_done) outst <= 1'b0;
            if (m_req) ar_run <= (m_op == 3'd1) ? ar_run + 1'b1 : '0;
        end
    end

    p_single_req_r13: assert property (@(posedge clk) disable iff (!rst_n)
        m_req |-> !outst);
    p_done_pulse_r1: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);
    p_refuse_quiet_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (done && err_code == 3'd1) |-> !req_seen);
    p_len_cap_r9: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (xfer_count <= 8'(MAX_XFER)));
    p_poll_bound_r8: assert property (@(posedge clk) disable iff (!rst_n)
        ar_run <= RW'(IN_TRIES + OUT_TRIES));
    p_req_in_op_r4: assert property (@(posedge clk) disable iff (!rst_n)
        m_req |-> busy);
    p_we_in_op_r11: assert property (@(posedge clk) disable iff (!rst_n)
        buf_we |-> busy);
endmodule

bind flash_prog_seq flash_prog_seq_chk #(
    .MAX_XFER(MAX_XFER), .IN_TRIES(IN_TRIES), .OUT_TRIES(OUT_TRIES)
) u_chk (
    .clk(clk), .rst_n(rst_n), .op_start(op_start), .done(done),
    .err_code(err_code), .xfer_count(xfer_count), .m_req(m_req),
    .m_op(m_op), .m_done(m_done), .buf_we(buf_we)
);

// File: tb/sim_flash_prog_seq.sv
module sim_flash_prog_seq;
    localparam int CLK_PERIOD = 10;
    localparam int WAIT_T     = 40;
    localparam int OUT_T      = 30;
    localparam int NV         = 7;
    // {op, offset, count, flash_size, expected length}
    localparam int VT [0:NV-1][0:4] = '{
        '{1, 16'h0000, 16,  32'h4000,  16},
        '{1, 16'h0100, 300, 32'h4000,  128},
        '{1, 16'h3FF0, 100, 32'h4000,  16},
        '{1, 16'h1234, 1,   32'h8000,  1},
        '{2, 16'h0200, 5,   32'h4000,  5},
        '{2, 16'h1FFE, 200, 32'h2000,  2},
        '{2, 16'h0000, 128, 32'h10000, 128}
    };

    logic clk = 1'b0, rst_n = 1'b0, tick_us = 1'b0, op_start = 1'b0;
    logic [2:0] op_code = '0;
    logic [15:0] offset = '0, count = '0;
    logic [16:0] flash_size = '0;
    logic done, m_req, m_done = 1'b0, m_fail = 1'b0, buf_we;
    logic [2:0] err_code, m_op;
    logic [7:0] xfer_count, m_wdata, m_rdata = '0, buf_wdata, buf_rdata;
    logic [6:0] buf_addr;

    flash_prog_seq #(.ENABLE_WAIT_US(WAIT_T), .OUT_TRIES(OUT_T)) u0 (
        .clk(clk), .rst_n(rst_n), .tick_us(tick_us), .op_start(op_start),
        .op_code(op_code), .offset(offset), .count(count), .flash_size(flash_size),
        .done(done), .err_code(err_code), .xfer_count(xfer_count),
        .m_req(m_req), .m_op(m_op), .m_wdata(m_wdata), .m_done(m_done),
        .m_fail(m_fail), .m_rdata(m_rdata), .buf_addr(buf_addr), .buf_we(buf_we),
        .buf_wdata(buf_wdata), .buf_rdata(buf_rdata));

    always #(CLK_PERIOD/2) clk = ~clk;

    int checks = 0, fails = 0, cyc = 0;
    int wn, req_n, ar_reads, rst_cnt, dr_rd_n, busy_left, lat = 0, last_done_cyc, tdiv = 0;
    int busy_n = 2;
    bit never_ready = 0, fail_dr = 0, sel_seen;
    logic [7:0] stat0 = 8'h0D, stat1 = 8'h0D, sel0, rd, cwd;
    logic [2:0] cop;
    logic [7:0] wlog [0:255];
    logic [7:0] bufm [0:127];
    logic [7:0] res_err, res_x;

    assign buf_rdata = bufm[buf_addr];

    // Target and master model: two-cycle latency per primitive.
    always @(posedge clk) begin
        m_done <= 1'b0;
        m_fail <= 1'b0;
        tdiv = (tdiv == 2) ? 0 : tdiv + 1;
        tick_us <= (tdiv == 0);
        if (lat == 1) begin
            rd = 8'h00;
            case (cop)
                3'd0: begin if (!sel_seen) begin sel0 = cwd; sel_seen = 1; end dr_rd_n = 0; end
                3'd1: begin
                    ar_reads++;
                    rd = {6'd0, busy_left > 0, !never_ready};
                    if (busy_left > 0) busy_left--;
                end
                3'd2: begin if (wn < 256) wlog[wn] = cwd; wn++; busy_left = busy_n; end
                3'd3: begin
                    rd = (dr_rd_n == 0) ? stat0 : (dr_rd_n == 1) ? stat1 : 8'((dr_rd_n - 2) * 13 + 5);
                    dr_rd_n++;
                    m_fail <= fail_dr;
                end
                default: rst_cnt++;
            endcase
            m_done <= 1'b1;
            m_rdata <= rd;
            last_done_cyc = cyc;
        end
        if (lat != 0) lat <= lat - 1;
        if (m_req) begin cop <= m_op; cwd <= m_wdata; lat <= 2; req_n++; end
        if (buf_we) bufm[buf_addr] <= buf_wdata;
    end

    // Watchdog: counts as a failed check and still prints the summary.
    always @(negedge clk) begin
        cyc++;
        if (cyc == 190000) begin
            fails++;
            $display("FAIL watchdog expired actual=%0d expected<%0d", cyc, 190000);
            $display("TB_RESULT checks=%0d failures=%0d", checks + 1, fails);
            $finish;
        end
    end

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic run(input int op, input int off, input int cnt, input int size);
        wn = 0; req_n = 0; ar_reads = 0; rst_cnt = 0; dr_rd_n = 0; sel_seen = 0; busy_left = 0;
        @(negedge clk);
        op_code = 3'(op); offset = 16'(off); count = 16'(cnt); flash_size = 17'(size);
        op_start = 1'b1;
        @(negedge clk);
        op_start = 1'b0;
        while (!done) @(negedge clk);
        res_err = 8'(err_code);
        res_x = xfer_count;
    endtask

    initial begin
        repeat (4) @(negedge clk);
        chk(done == 0 && err_code == 0 && xfer_count == 0 && m_req == 0 && buf_we == 0,
            "R1 reset state", {done, m_req, buf_we}, 0);
        rst_n = 1'b1;

        // R3: refused before unlock
        run(1, 0, 4, 32'h4000);
        chk(res_err == 1 && req_n == 0, "R3 refuse before unlock", res_err * 256 + req_n, 1 * 256);

        // R10: unknown operation code
        run(6, 0, 4, 32'h4000);
        chk(res_err == 4 && req_n == 0, "R10 unknown op rejected", res_err * 256 + req_n, 4 * 256);

        // R2: unlock script and settling wait
        run(0, 0, 0, 0);
        chk(res_err == 0 && sel0 == 8'h02 && wn == 2 && wlog[0] == 8'h02 && wlog[1] == 8'h01,
            "R2 unlock script", {res_err, sel0, wlog[0], wlog[1]}, 32'h00020201);
        chk(cyc - last_done_cyc >= WAIT_T * 3 - 5 && cyc - last_done_cyc <= WAIT_T * 3 + 20,
            "R2 unlock wait", cyc - last_done_cyc, WAIT_T * 3);

        // R5, R9, R11: table of block transfers
        for (int v = 0; v < NV; v++) begin
            int len, bad;
            len = VT[v][4];
            if (VT[v][0] == 2) for (int k = 0; k < 128; k++) bufm[k] = 8'(k) ^ 8'h5A;
            else for (int k = 0; k < 128; k++) bufm[k] = 8'hEE;
            run(VT[v][0], VT[v][1], VT[v][2], VT[v][3]);
            chk(res_err == 0 && res_x == 8'(len), "R9 length and result", res_err * 256 + res_x, len);
            chk(sel0 == 8'hB4 && wlog[0] == (VT[v][0] == 1 ? 8'h06 : 8'h07) &&
                wlog[1] == 8'(VT[v][1] >> 8) && wlog[2] == 8'(VT[v][1]) && wlog[3] == 8'(len),
                "R5 command header", {wlog[0], wlog[1], wlog[2], wlog[3]}, v);
            bad = 0;
            if (VT[v][0] == 1) begin
                for (int k = 0; k < len; k++) if (bufm[k] != 8'(k * 13 + 5)) bad++;
                if (len < 128 && bufm[len] != 8'hEE) bad++;
                if (wn != 4) bad++;
            end else begin
                for (int k = 0; k < len; k++) if (wlog[4 + k] != (8'(k) ^ 8'h5A)) bad++;
                if (wn != 4 + len) bad++;
            end
            chk(bad == 0, "R11 data bytes", bad, 0);
        end

        // R12: erase arming sequence
        run(3, 0, 0, 32'h4000);
        chk(res_err == 0 && wn == 4 && wlog[0] == 8'h03 && wlog[1] == 8'hDE &&
            wlog[2] == 8'hAD && wlog[3] == 8'hA5, "R12 erase arming",
            {wlog[0], wlog[1], wlog[2], wlog[3]}, 32'h03DEADA5);

        // R7: busy clears on the last allowed try, then one try too many
        busy_n = 19;
        run(3, 0, 0, 32'h4000);
        chk(res_err == 0, "R7 last try succeeds", res_err, 0);
        busy_n = 20;
        run(3, 0, 0, 32'h4000);
        chk(res_err == 3 && ar_reads == 20 && wn == 1, "R7 busy timeout",
            res_err * 256 + ar_reads, 3 * 256 + 20);
        busy_n = 2;

        // R8: output never ready
        busy_n = 0; never_ready = 1;
        run(3, 0, 0, 32'h4000);
        chk(res_err == 3 && ar_reads == 1 + OUT_T, "R8 ready timeout",
            res_err * 256 + ar_reads, 3 * 256 + 1 + OUT_T);
        never_ready = 0; busy_n = 2;

        // R6: rejected status
        stat0 = 8'h02;
        run(1, 0, 8, 32'h4000);
        chk(res_err == 2 && wn == 1, "R6 bad status", res_err * 256 + wn, 2 * 256 + 1);
        stat0 = 8'h0D; stat1 = 8'h00;
        run(2, 0, 8, 32'h4000);
        chk(res_err == 2 && wn == 4 && res_x == 0, "R6 bad second status", res_err * 256 + wn, 2 * 256 + 4);
        stat1 = 8'h0D;

        // R10: range cases
        run(2, 16'h4000, 8, 32'h4000);
        chk(res_err == 4 && req_n == 0, "R10 write past end", res_err * 256 + req_n, 4 * 256);
        run(1, 16'h4000, 8, 32'h4000);
        chk(res_err == 0 && res_x == 0 && req_n == 0, "R10 read past end",
            res_err * 256 + res_x + req_n, 0);
        run(2, 16'h0010, 0, 32'h4000);
        chk(res_err == 0 && res_x == 0 && req_n == 0, "R10 zero count write",
            res_err * 256 + res_x + req_n, 0);

        // R13: master failure
        fail_dr = 1;
        run(1, 0, 4, 32'h4000);
        chk(res_err == 3, "R13 master fail", res_err, 3);
        fail_dr = 0;

        // R4: reset operation revokes unlock
        run(4, 0, 0, 0);
        chk(res_err == 0 && rst_cnt == 1 && req_n == 1, "R4 reset request",
            res_err * 256 + rst_cnt, 1);
        run(3, 0, 0, 32'h4000);
        chk(res_err == 1 && req_n == 0, "R4 unlock revoked", res_err * 256 + req_n, 1 * 256);

        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule